// File: doc/BRIEF.md
# NAND Cache Program Sequencer

This block runs on the host side of a NAND flash link and writes a run of pages using cache programming. A page request carries the five-byte target address and a flag saying whether it is the final page of the run. For each request the sequencer sends the setup command, the address bytes and one page of bytes taken from a separate byte stream. It then closes the page, issues a status command and reads the status byte until the device is ready. Every setup uses the single-plane command, so a run that starts in single-plane cache mode stays in that mode until its final page.

Pages other than the last are closed with the cache confirm. The sequencer then waits only for the cache-ready bit, and the pass/fail bit for the previous page comes back at that point. The last page is closed with the plain program confirm. The sequencer then waits for the true-ready bit and takes both the previous page's result and its own. Results leave on a valid-only stream in the same order the pages were accepted. A poll limit turns a device that never becomes ready into one timeout record, and the run is abandoned.

Top module: `ncp_cache_prog_seq`

## Requirements
- R1: During and right after reset, every bus strobe (`nand_cmd_we`, `nand_adr_we`, `nand_dat_we`, `nand_sts_re`) and `res_valid` are low and `req_ready` is high.
- R2: Each accepted page appears on `nand_io_out` as command 80h, then exactly ADDR_CYC address strobes carrying `req_addr` with bits 7:0 first, then PAGE_BYTES data strobes carrying the stream bytes in arrival order. No other setup opcode is ever used.
- R3: The page is closed by command 15h when `req_last` was 0 and by 10h when it was 1.
- R4: The closing command is followed on the next cycle by command 70h. Status reads (`nand_sts_re`) follow on every later cycle, and `nand_io_in` is sampled at the end of each read cycle. A 15h page waits for bit 6 = 1 and a 10h page waits for bit 5 = 1. No new request is accepted while reads continue.
- R5: When a 15h or 10h page becomes ready and an earlier page of the same run is still unreported, one record is emitted with `res_fail` equal to status bit 1. The first page of a run emits nothing at that point.
- R6: When the last page becomes ready, the record for the previous page (if any) comes first. The last page's record follows on the next cycle with `res_fail` equal to status bit 0. Records appear in the order the pages were issued.
- R7: If the awaited ready bit is still 0 after POLL_LIMIT status reads, exactly one record with `res_timeout` = 1 and `res_fail` = 1 is emitted. The run is then abandoned, with any pending result dropped, and the sequencer returns to accepting requests.
- R8: `dat_ready` is high only in the data phase, and bytes offered at other times are not taken. At most one bus strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Page request offered |
| req_ready | output | 1 | Request accepted when both high |
| req_addr | input | 8*ADDR_CYC | Page address, bits 7:0 sent first |
| req_last | input | 1 | Request is the final page of the run |
| dat_valid | input | 1 | Data byte offered |
| dat_ready | output | 1 | Data byte taken when both high |
| dat_byte | input | 8 | Data byte |
| nand_io_out | output | 8 | Byte driven to the device |
| nand_cmd_we | output | 1 | Command strobe |
| nand_adr_we | output | 1 | Address strobe |
| nand_dat_we | output | 1 | Data strobe |
| nand_sts_re | output | 1 | Status read strobe |
| nand_io_in | input | 8 | Status byte from the device |
| res_valid | output | 1 | Result record valid (one cycle) |
| res_fail | output | 1 | Page failed (or timed out) |
| res_timeout | output | 1 | Record reports a poll timeout |

## Verification
The hardest situation to reach is a final page whose status reports cache-ready long before true-ready, while the device also returns a previous-page result. In that case the sequencer must ignore bit 6, wait on bit 5 and then send two records on consecutive cycles. The bench's device model drives bit 6 high at once on final pages and holds bit 5 low for a random number of reads. On cache pages it holds bit 5 low and fills bit 0 with noise, so waiting on the wrong bit or taking the wrong result bit changes the observed sequence. Runs of random length, directed timeouts on both kinds of page, and a fresh run after each timeout cover dropping a pending result.

// File: rtl/ncp_pkg.sv
package ncp_pkg;

  localparam logic [7:0] OP_SETUP  = 8'h80;
  localparam logic [7:0] OP_CACHE  = 8'h15;
  localparam logic [7:0] OP_FINAL  = 8'h10;
  localparam logic [7:0] OP_STATUS = 8'h70;

  localparam int SB_CUR       = 0;
  localparam int SB_PREV      = 1;
  localparam int SB_TRUE_RDY  = 5;
  localparam int SB_CACHE_RDY = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ADDR, ST_DATA, ST_CONF, ST_STCMD, ST_POLL, ST_FINAL
  } state_e;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SETUP, SEL_ADDR, SEL_DATA, SEL_CONF_CACHE, SEL_CONF_LAST, SEL_STATUS
  } bsel_e;

endpackage

// File: rtl/ncp_poll_timer.sv
module ncp_poll_timer #(
  parameter int POLL_LIMIT = 4096,
  localparam int CW = $clog2(POLL_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic last_try
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en   = clr | tick;
  assign cnt_d    = clr ? '0 : cnt_q + CW'(1);
  assign last_try = (cnt_q == CW'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ncp_ctrl.sv
module ncp_ctrl
  import ncp_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int ADDR_CYC   = 5,
  localparam int AIW = $clog2(ADDR_CYC + 1),
  localparam int BW  = $clog2(PAGE_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_last,
  input  logic           dat_valid,
  input  logic           sts_cache_rdy,
  input  logic           sts_true_rdy,
  input  logic           sts_prev_fail,
  input  logic           sts_cur_fail,
  input  logic           poll_last_try,
  output logic           req_ready,
  output logic           dat_ready,
  output logic           cmd_we,
  output logic           adr_we,
  output logic           dat_we,
  output logic           sts_re,
  output bsel_e          bsel,
  output logic [AIW-1:0] adr_idx,
  output logic           load_req,
  output logic           tmr_clr,
  output logic           tmr_tick,
  output logic           emit_valid,
  output logic           emit_fail,
  output logic           emit_timeout
);

  state_e         state_q, state_d;
  logic [AIW-1:0] acnt_q, acnt_d;
  logic [BW-1:0]  bcnt_q, bcnt_d;
  logic           last_q, last_d;
  logic           pend_q, pend_d;
  logic           curf_q, curf_d;
  logic           rdy;

  assign adr_idx = acnt_q;
  assign rdy     = last_q ? sts_true_rdy : sts_cache_rdy;

  always_comb begin
    state_d      = state_q;
    acnt_d       = acnt_q;
    bcnt_d       = bcnt_q;
    last_d       = last_q;
    pend_d       = pend_q;
    curf_d       = curf_q;
    req_ready    = 1'b0;
    dat_ready    = 1'b0;
    cmd_we       = 1'b0;
    adr_we       = 1'b0;
    dat_we       = 1'b0;
    sts_re       = 1'b0;
    bsel         = SEL_NONE;
    load_req     = 1'b0;
    tmr_clr      = 1'b0;
    tmr_tick     = 1'b0;
    emit_valid   = 1'b0;
    emit_fail    = 1'b0;
    emit_timeout = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          load_req = 1'b1;
          last_d   = req_last;
          state_d  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        cmd_we  = 1'b1;
        bsel    = SEL_SETUP;
        acnt_d  = '0;
        state_d = ST_ADDR;
      end
      ST_ADDR: begin
        adr_we = 1'b1;
        bsel   = SEL_ADDR;
        if (acnt_q == AIW'(ADDR_CYC - 1)) begin
          bcnt_d  = '0;
          state_d = ST_DATA;
        end else begin
          acnt_d = acnt_q + AIW'(1);
        end
      end
      ST_DATA: begin
        dat_ready = 1'b1;
        if (dat_valid) begin
          dat_we = 1'b1;
          bsel   = SEL_DATA;
          if (bcnt_q == BW'(PAGE_BYTES - 1)) state_d = ST_CONF;
          else                               bcnt_d  = bcnt_q + BW'(1);
        end
      end
      ST_CONF: begin
        cmd_we  = 1'b1;
        bsel    = last_q ? SEL_CONF_LAST : SEL_CONF_CACHE;
        state_d = ST_STCMD;
      end
      ST_STCMD: begin
        cmd_we  = 1'b1;
        bsel    = SEL_STATUS;
        tmr_clr = 1'b1;
        state_d = ST_POLL;
      end
      ST_POLL: begin
        sts_re = 1'b1;
        if (rdy) begin
          emit_valid = pend_q;
          emit_fail  = sts_prev_fail;
          if (last_q) begin
            curf_d  = sts_cur_fail;
            pend_d  = 1'b0;
            state_d = ST_FINAL;
          end else begin
            pend_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end else if (poll_last_try) begin
          emit_valid   = 1'b1;
          emit_fail    = 1'b1;
          emit_timeout = 1'b1;
          pend_d       = 1'b0;
          state_d      = ST_IDLE;
        end else begin
          tmr_tick = 1'b1;
        end
      end
      ST_FINAL: begin
        emit_valid = 1'b1;
        emit_fail  = curf_q;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      acnt_q  <= '0;
      bcnt_q  <= '0;
      last_q  <= 1'b0;
      pend_q  <= 1'b0;
      curf_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      acnt_q  <= acnt_d;
      bcnt_q  <= bcnt_d;
      last_q  <= last_d;
      pend_q  <= pend_d;
      curf_q  <= curf_d;
    end
  end

endmodule

// File: rtl/ncp_bus_drv.sv
module ncp_bus_drv
  import ncp_pkg::*;
#(
  parameter int ADDR_CYC = 5,
  localparam int AIW = $clog2(ADDR_CYC + 1),
  localparam int AW  = 8 * ADDR_CYC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  req_addr,
  input  logic [AIW-1:0] adr_idx,
  input  bsel_e          bsel,
  input  logic [7:0]     dat_byte,
  output logic [7:0]     io_out
);

  logic [AW-1:0]               addr_q;
  logic [ADDR_CYC-1:0][7:0]    masked;
  logic [7:0]                  addr_pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= req_addr;
  end

  for (genvar g = 0; g < ADDR_CYC; g++) begin : g_abyte
    assign masked[g] = (adr_idx == AIW'(g)) ? addr_q[8*g +: 8] : 8'h00;
  end

  always_comb begin
    addr_pick = 8'h00;
    for (int i = 0; i < ADDR_CYC; i++) addr_pick = addr_pick | masked[i];
  end

  always_comb begin
    unique case (bsel)
      SEL_SETUP:      io_out = OP_SETUP;
      SEL_ADDR:       io_out = addr_pick;
      SEL_DATA:       io_out = dat_byte;
      SEL_CONF_CACHE: io_out = OP_CACHE;
      SEL_CONF_LAST:  io_out = OP_FINAL;
      SEL_STATUS:     io_out = OP_STATUS;
      default:        io_out = 8'h00;
    endcase
  end

endmodule

// File: rtl/ncp_result.sv
module ncp_result (
  input  logic clk,
  input  logic rst_n,
  input  logic emit_valid,
  input  logic emit_fail,
  input  logic emit_timeout,
  output logic res_valid,
  output logic res_fail,
  output logic res_timeout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_valid <= 1'b0;
    else        res_valid <= emit_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_fail    <= 1'b0;
      res_timeout <= 1'b0;
    end else if (emit_valid) begin
      res_fail    <= emit_fail;
      res_timeout <= emit_timeout;
    end
  end

endmodule

// File: rtl/ncp_cache_prog_seq.sv
module ncp_cache_prog_seq
  import ncp_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int ADDR_CYC   = 5,
  parameter int POLL_LIMIT = 4096,
  localparam int AIW = $clog2(ADDR_CYC + 1),
  localparam int AW  = 8 * ADDR_CYC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_last,
  input  logic          dat_valid,
  output logic          dat_ready,
  input  logic [7:0]    dat_byte,
  output logic [7:0]    nand_io_out,
  output logic          nand_cmd_we,
  output logic          nand_adr_we,
  output logic          nand_dat_we,
  output logic          nand_sts_re,
  input  logic [7:0]    nand_io_in,
  output logic          res_valid,
  output logic          res_fail,
  output logic          res_timeout
);

  bsel_e          bsel;
  logic [AIW-1:0] adr_idx;
  logic           load_req;
  logic           tmr_clr;
  logic           tmr_tick;
  logic           last_try;
  logic           emit_valid;
  logic           emit_fail;
  logic           emit_timeout;
  logic           unused_sts_bits;

  assign unused_sts_bits = ^{nand_io_in[7], nand_io_in[4:2]};

  ncp_ctrl #(.PAGE_BYTES(PAGE_BYTES), .ADDR_CYC(ADDR_CYC)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_last      (req_last),
    .dat_valid     (dat_valid),
    .sts_cache_rdy (nand_io_in[SB_CACHE_RDY]),
    .sts_true_rdy  (nand_io_in[SB_TRUE_RDY]),
    .sts_prev_fail (nand_io_in[SB_PREV]),
    .sts_cur_fail  (nand_io_in[SB_CUR]),
    .poll_last_try (last_try),
    .req_ready     (req_ready),
    .dat_ready     (dat_ready),
    .cmd_we        (nand_cmd_we),
    .adr_we        (nand_adr_we),
    .dat_we        (nand_dat_we),
    .sts_re        (nand_sts_re),
    .bsel          (bsel),
    .adr_idx       (adr_idx),
    .load_req      (load_req),
    .tmr_clr       (tmr_clr),
    .tmr_tick      (tmr_tick),
    .emit_valid    (emit_valid),
    .emit_fail     (emit_fail),
    .emit_timeout  (emit_timeout)
  );

  ncp_bus_drv #(.ADDR_CYC(ADDR_CYC)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_req),
    .req_addr (req_addr),
    .adr_idx  (adr_idx),
    .bsel     (bsel),
    .dat_byte (dat_byte),
    .io_out   (nand_io_out)
  );

  ncp_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .tick     (tmr_tick),
    .last_try (last_try)
  );

  ncp_result u_res (
    .clk          (clk),
    .rst_n        (rst_n),
    .emit_valid   (emit_valid),
    .emit_fail    (emit_fail),
    .emit_timeout (emit_timeout),
    .res_valid    (res_valid),
    .res_fail     (res_fail),
    .res_timeout  (res_timeout)
  );

endmodule

// File: rtl/ncp_cache_prog_seq_chk.sv
module ncp_cache_prog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       dat_ready,
  input logic [7:0] nand_io_out,
  input logic       nand_cmd_we,
  input logic       nand_adr_we,
  input logic       nand_dat_we,
  input logic       nand_sts_re,
  input logic       res_valid,
  input logic       res_fail,
  input logic       res_timeout
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nand_cmd_we, nand_adr_we, nand_dat_we, nand_sts_re})); // R8

  AST_DATA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cmd_we || nand_adr_we || nand_sts_re) |-> !dat_ready); // R8

  AST_SETUP_THEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cmd_we && nand_io_out == 8'h80) |=> nand_adr_we); // R2

  AST_CONF_THEN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cmd_we && (nand_io_out == 8'h15 || nand_io_out == 8'h10))
      |=> (nand_cmd_we && nand_io_out == 8'h70)); // R4

  AST_STATUS_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cmd_we && nand_io_out == 8'h70) |=> nand_sts_re); // R4

  AST_NO_REQ_DURING_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    nand_sts_re |-> !req_ready); // R4

  AST_TIMEOUT_IS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_timeout) |-> res_fail); // R7

  AST_IDLE_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_timeout) |-> req_ready); // R7

endmodule

bind ncp_cache_prog_seq ncp_cache_prog_seq_chk u_chk (.*);

// File: tb/ncp_cache_prog_seq_tb.sv
module ncp_cache_prog_seq_tb;

  localparam int PB  = 6;
  localparam int AC  = 5;
  localparam int LIM = 20;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [8*AC-1:0] req_addr;
  logic          req_last;
  logic          dat_valid;
  logic          dat_ready;
  logic [7:0]    dat_byte;
  logic [7:0]    nand_io_out;
  logic          nand_cmd_we;
  logic          nand_adr_we;
  logic          nand_dat_we;
  logic          nand_sts_re;
  logic [7:0]    nand_io_in;
  logic          res_valid;
  logic          res_fail;
  logic          res_timeout;

  ncp_cache_prog_seq #(.PAGE_BYTES(PB), .ADDR_CYC(AC), .POLL_LIMIT(LIM)) u_dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk;
  int n_fail;

  logic [9:0] ev_q[$];
  logic [1:0] res_q[$];

  int   m_busy;
  int   m_busy_set;
  int   m_reads;
  bit   m_last;
  bit   m_curf;
  bit   m_prevf;
  bit   pv;
  bit   pf;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [9:0] e);
    if (e[9:8] == 2'd0 && (e[7:0] == 8'h10 || e[7:0] == 8'h15)) return "R3";
    if (e[9:8] == 2'd0 && e[7:0] == 8'h70) return "R4";
    return "R2";
  endfunction

  // device model and monitor
  initial begin
    nand_io_in = 8'h00;
    m_busy = 0; m_reads = 0; m_last = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (nand_cmd_we || nand_adr_we || nand_dat_we) begin
          logic [1:0] ty;
          logic [9:0] e;
          ty = nand_cmd_we ? 2'd0 : (nand_adr_we ? 2'd1 : 2'd2);
          if (ev_q.size() == 0) begin
            chk(1'b0, "R2", {ty, nand_io_out}, 0);
          end else begin
            e = ev_q.pop_front();
            chk(e == {ty, nand_io_out}, tag_of(e), {ty, nand_io_out}, e);
          end
          if (nand_cmd_we && (nand_io_out == 8'h10 || nand_io_out == 8'h15)) begin
            m_busy  = m_busy_set;
            m_last  = (nand_io_out == 8'h10);
            m_reads = 0;
          end
        end
        if (nand_cmd_we || nand_adr_we) chk(!dat_ready, "R8", dat_ready, 0);
        if (nand_sts_re) begin
          bit rdy;
          m_reads++;
          rdy = (m_busy == 0);
          if (m_busy > 0) m_busy--;
          nand_io_in = 8'h00;
          nand_io_in[6] = m_last ? 1'b1 : rdy;
          nand_io_in[5] = m_last ? rdy : 1'b0;
          nand_io_in[1] = m_prevf;
          nand_io_in[0] = m_last ? m_curf : 1'($urandom);
          chk(!req_ready, "R4", req_ready, 0);
        end
        if (res_valid) begin
          logic [1:0] r;
          if (res_q.size() == 0) begin
            chk(1'b0, "R6", {res_timeout, res_fail}, 0);
          end else begin
            r = res_q.pop_front();
            chk(r == {res_timeout, res_fail}, r[1] ? "R7" : "R5", {res_timeout, res_fail}, r);
            if (r[1]) chk(m_reads == LIM, "R7", m_reads, LIM);
          end
        end
      end
    end
  end

  task automatic run_page(input logic [8*AC-1:0] a, input bit last, input int busy,
                          input bit fail, input bit tmo);
    logic [7:0] d [PB];
    for (int i = 0; i < PB; i++) d[i] = 8'($urandom);
    m_busy_set = tmo ? LIM + 5 : busy;
    m_curf  = fail;
    m_prevf = pv ? pf : 1'($urandom);
    ev_q.push_back({2'd0, 8'h80});
    for (int i = 0; i < AC; i++) ev_q.push_back({2'd1, a[8*i +: 8]});
    for (int i = 0; i < PB; i++) ev_q.push_back({2'd2, d[i]});
    ev_q.push_back({2'd0, last ? 8'h10 : 8'h15});
    ev_q.push_back({2'd0, 8'h70});
    if (tmo) begin
      res_q.push_back(2'b11);
      pv = 1'b0;
    end else begin
      if (pv) res_q.push_back({1'b0, pf});
      if (last) begin
        res_q.push_back({1'b0, fail});
        pv = 1'b0;
      end else begin
        pv = 1'b1;
        pf = fail;
      end
    end
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_last = last;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int i = 0; i < PB; i++) begin
      int g;
      g = int'($urandom % 3);
      repeat (g) begin @(posedge clk); #1; end
      dat_valid = 1'b1; dat_byte = d[i];
      do @(negedge clk); while (!dat_ready);
      @(posedge clk); #1;
      dat_valid = 1'b0;
    end
    do @(negedge clk); while (!req_ready);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3a5));
    n_chk = 0; n_fail = 0; pv = 1'b0; pf = 1'b0;
    m_busy_set = 0; m_curf = 1'b0; m_prevf = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_last = 1'b0;
    dat_valid = 1'b0; dat_byte = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({nand_cmd_we, nand_adr_we, nand_dat_we, nand_sts_re, res_valid} == 5'b0, "R1",
        {nand_cmd_we, nand_adr_we, nand_dat_we, nand_sts_re, res_valid}, 0);
    chk(req_ready, "R1", req_ready, 1);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({nand_cmd_we, nand_adr_we, nand_dat_we, nand_sts_re, res_valid} == 5'b0, "R1",
        {nand_cmd_we, nand_adr_we, nand_dat_we, nand_sts_re, res_valid}, 0);
    chk(req_ready, "R1", req_ready, 1);

    // R6: single final page, no previous result, immediate ready
    run_page(40'h01_2345_6789, 1'b1, 0, 1'b1, 1'b0);
    // R5, R6: two-page run with busy device
    run_page(40'hA0_B0C0_D0E0, 1'b0, 3, 1'b1, 1'b0);
    run_page(40'hA0_B0C0_D0E1, 1'b1, 4, 1'b0, 1'b0);
    // R7: timeout on a cache page with a pending previous result
    run_page(40'h11_1111_1111, 1'b0, 2, 1'b0, 1'b0);
    run_page(40'h22_2222_2222, 1'b0, 0, 1'b0, 1'b1);
    // R7: fresh run after timeout reports nothing stale
    run_page(40'h33_3333_3333, 1'b0, 1, 1'b1, 1'b0);
    run_page(40'h44_4444_4444, 1'b1, 2, 1'b1, 1'b0);
    // R7: timeout on a final page
    run_page(40'h55_5555_5555, 1'b1, 0, 1'b0, 1'b1);

    // random runs
    for (int r = 0; r < 10; r++) begin
      int n;
      n = 1 + int'($urandom % 4);
      for (int p = 0; p < n; p++) begin
        run_page({8'($urandom), 32'($urandom)}, p == n - 1, int'($urandom % 6),
                 1'($urandom), 1'b0);
      end
    end

    repeat (5) @(negedge clk);
    chk(ev_q.size() == 0, "R2", ev_q.size(), 0);
    chk(res_q.size() == 0, "R6", res_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule